// File: doc/BRIEF.md
# Page Write Buffer and Erase/Write Sequencer

This block sits between a serial-bus slave controller and a behavioural non-volatile storage array. During a write transaction the controller hands it each received data byte together with the byte's offset inside the current page. The bytes are held in a page-sized holding register, and a per-byte valid mask records which offsets were filled. The page number is latched from a separate load strobe when the word address arrives.

Nothing reaches the array until the controller reports the bus STOP. A STOP starts a cycle only when three things are true: the block is idle, at least one byte is buffered, and write protection is low. The cycle then does two things:

- It walks the page offsets in ascending order and issues one array write for each offset whose valid bit is set.
- It holds the busy flag for a fixed number of timer ticks. The controller uses that flag to refuse every bus access.

A STOP that does not start a cycle throws the buffer away. While busy is high, every input except the tick is ignored. The cycle length is a parameter counted in ticks. Holding the tick high makes one tick equal one system clock.

Top module: `ew_page_seq`

## Requirements
- R1: After reset, busy_o and mem_we_o are low, the valid mask is empty, and the first STOP with no data starts no cycle.
- R2: A data byte accepted at offset o is committed to address page*PAGE_BYTES + o, where page is the value most recently loaded through page_ld_i while idle. The address puts the page number above the OFF_W offset bits.
- R3: A STOP sampled while idle, with wp_i low and at least one byte buffered, raises busy_o at the next clock edge.
- R4: During a cycle, exactly one array write is issued for each buffered offset and none for any other offset. The writes come one per clock in ascending offset order, starting in the first busy cycle, and mem_we_o is never high while busy_o is low.
- R5: When one offset is written more than once before STOP, only the last byte is committed, and it is committed once.
- R6: A byte strobed while wp_i is high is discarded. A STOP sampled while wp_i is high starts no cycle and discards every buffered byte.
- R7: A STOP sampled while idle with an empty buffer starts no cycle and issues no write.
- R8: With tick_i held high, busy_o stays high for exactly EW_TICKS+1 clocks, whatever the number of bytes committed. It falls on the clock after the tick counter reaches zero.
- R9: While busy_o is high, data strobes, page loads and STOP have no effect. They add no buffered byte, leave the page unchanged and start no further cycle.
- R10: At the end of a cycle the valid mask is empty, so a following STOP with no new data starts no cycle.
- R11: The cycle counter advances only on clocks where tick_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| page_ld_i | input | 1 | Load the page number of the transaction |
| page_i | input | ADDR_W-OFF_W | Page number to load |
| wr_stb_i | input | 1 | A data byte is presented |
| wr_off_i | input | OFF_W | Offset of the byte inside the page |
| wr_data_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Bus STOP seen (one-clock pulse) |
| wp_i | input | 1 | Write protect; high discards data and blocks the cycle |
| tick_i | input | 1 | Timebase enable for the cycle counter |
| busy_o | output | 1 | Erase/write cycle in progress; bus access refused |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | DATA_W | Array write data |

## Verification
The assertions assume that the controller pulses stop_i for a single clock and never in the same clock as wr_stb_i. They also assume that EW_TICKS is at least PAGE_BYTES, so that the offset walk always ends before the counter does.

The stimulus meets these assumptions by construction:
- Every page load, byte strobe and STOP takes its own clock.
- The small configuration uses 8-byte pages and a 12-tick cycle.

Beyond that, the stimulus sweeps every non-empty valid mask of an 8-byte page, strobing the offsets in descending order to exercise the commit order. Write protection, the lockout window and gated ticks are driven only in separate directed sequences, so their timing is known exactly.

// File: rtl/ew_pkg.sv
package ew_pkg;
  typedef enum logic [1:0] {
    EW_IDLE   = 2'd0,
    EW_COMMIT = 2'd1,
    EW_HOLD   = 2'd2
  } ew_state_e;
endpackage

// File: rtl/ew_page_buf.sv
module ew_page_buf #(
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W     = 8,
  parameter int PAGE_W     = 6,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  lock_i,
  input  logic                  clr_i,
  input  logic                  page_ld_i,
  input  logic [PAGE_W-1:0]     page_i,
  input  logic                  wr_i,
  input  logic [OFF_W-1:0]      off_i,
  input  logic [DATA_W-1:0]     data_i,
  input  logic                  wp_i,
  input  logic [OFF_W-1:0]      rd_off_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic [PAGE_BYTES-1:0] valid_o,
  output logic [PAGE_W-1:0]     page_o
);
  logic [DATA_W-1:0]     data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;
  logic [PAGE_W-1:0]     page_q;
  logic                  accept;

  assign accept = wr_i && !lock_i && !wp_i;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
    logic hit;
    assign hit = accept && (off_i == OFF_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g]  <= '0;
        valid_q[g] <= 1'b0;
      end else if (clr_i) begin
        valid_q[g] <= 1'b0;
      end else if (hit) begin
        data_q[g]  <= data_i;
        valid_q[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   page_q <= '0;
    else if (page_ld_i && !lock_i) page_q <= page_i;
  end

  assign rd_data_o = data_q[rd_off_i];
  assign valid_o   = valid_q;
  assign page_o    = page_q;

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i && !clr_i |=> $stable(valid_q) && $stable(page_q)); // R9
  AST_WP_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i && !clr_i |=> $countones(valid_q) <= $countones($past(valid_q))); // R6
endmodule

// File: rtl/ew_timer.sv
module ew_timer #(
  parameter int EW_TICKS = 2_500_000,
  localparam int CNT_W   = $clog2(EW_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  input  logic tick_i,
  output logic expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (load_i)                        cnt_q <= CNT_W'(EW_TICKS);
    else if (run_i && tick_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  AST_TICK_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !tick_i |=> $stable(cnt_q)); // R11
  AST_CNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> cnt_q <= $past(cnt_q)); // R8
endmodule

// File: rtl/ew_ctrl.sv
module ew_ctrl
  import ew_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic             wp_i,
  input  logic             any_valid_i,
  input  logic             cur_valid_i,
  input  logic             expired_i,
  output logic             busy_o,
  output logic             start_o,
  output logic             clr_o,
  output logic [OFF_W-1:0] idx_o,
  output logic             we_o
);
  ew_state_e        state_q, state_d;
  logic [OFF_W-1:0] idx_q;
  logic             idle, drop, finish;

  assign idle    = (state_q == EW_IDLE);
  assign start_o = idle && stop_i && !wp_i && any_valid_i;
  assign drop    = idle && stop_i && !start_o;
  assign finish  = (state_q == EW_HOLD) && expired_i;
  assign clr_o   = drop || finish;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      EW_IDLE:   if (start_o) state_d = EW_COMMIT;
      EW_COMMIT: if (idx_q == OFF_W'(PAGE_BYTES - 1)) state_d = EW_HOLD;
      EW_HOLD:   if (expired_i) state_d = EW_IDLE;
      default:   state_d = EW_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= EW_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start_o)                     idx_q <= '0;
      else if (state_q == EW_COMMIT)   idx_q <= idx_q + 1'b1;
    end
  end

  assign busy_o = !idle;
  assign idx_o  = idx_q;
  assign we_o   = (state_q == EW_COMMIT) && cur_valid_i;

  AST_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && stop_i && !wp_i && any_valid_i |=> busy_o); // R3
  AST_WP_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && stop_i && wp_i |=> !busy_o); // R6
  AST_EMPTY_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && stop_i && !any_valid_i |=> !busy_o); // R7
  AST_WE_IN_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> busy_o); // R4
  AST_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_o) && we_o && $past(busy_o) |-> idx_q > $past(idx_q)); // R4
  AST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && expired_i && !we_o && state_q == EW_HOLD |=> !busy_o && !any_valid_i); // R10
endmodule

// File: rtl/ew_page_seq.sv
module ew_page_seq #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W     = 8,
  parameter int EW_TICKS   = 2_500_000,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              page_ld_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              wr_stb_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  logic [PAGE_BYTES-1:0] valid;
  logic [PAGE_W-1:0]     page;
  logic [OFF_W-1:0]      idx;
  logic [DATA_W-1:0]     rd_data;
  logic                  busy, start, clr, expired;

  ew_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_buf (
    .clk_i, .rst_ni,
    .lock_i   (busy),
    .clr_i    (clr),
    .page_ld_i,
    .page_i,
    .wr_i     (wr_stb_i),
    .off_i    (wr_off_i),
    .data_i   (wr_data_i),
    .wp_i,
    .rd_off_i (idx),
    .rd_data_o(rd_data),
    .valid_o  (valid),
    .page_o   (page)
  );

  ew_timer #(.EW_TICKS(EW_TICKS)) u_tmr (
    .clk_i, .rst_ni,
    .load_i   (start),
    .run_i    (busy),
    .tick_i,
    .expired_o(expired)
  );

  ew_ctrl #(.PAGE_BYTES(PAGE_BYTES)) u_ctl (
    .clk_i, .rst_ni,
    .stop_i,
    .wp_i,
    .any_valid_i(|valid),
    .cur_valid_i(valid[idx]),
    .expired_i  (expired),
    .busy_o     (busy),
    .start_o    (start),
    .clr_o      (clr),
    .idx_o      (idx),
    .we_o       (mem_we_o)
  );

  assign busy_o     = busy;
  assign mem_addr_o = {page, idx};
  assign mem_data_o = rd_data;

  AST_PAGE_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(mem_addr_o[ADDR_W-1:OFF_W])); // R2
endmodule

// File: tb/sim_ew_page_seq.sv
`timescale 1ns/1ps
module sim_ew_page_seq;
  localparam int ADDR_W = 7;
  localparam int PB     = 8;
  localparam int DW     = 8;
  localparam int EW     = 12;
  localparam int OFF_W  = $clog2(PB);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic page_ld = 1'b0, wr_stb = 1'b0, stop = 1'b0, wp = 1'b0, tick = 1'b1;
  logic [PAGE_W-1:0] page = '0;
  logic [OFF_W-1:0]  woff = '0;
  logic [DW-1:0]     wdat = '0;
  logic busy, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DW-1:0]     mem_data;

  int checks = 0, errors = 0;
  int log_n = 0, exp_n = 0;
  int log_a [64], log_d [64], exp_a [64], exp_d [64];

  always #2 clk = ~clk;

  ew_page_seq #(.ADDR_W(ADDR_W), .PAGE_BYTES(PB), .DATA_W(DW), .EW_TICKS(EW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .page_ld_i(page_ld), .page_i(page),
    .wr_stb_i(wr_stb), .wr_off_i(woff), .wr_data_i(wdat), .stop_i(stop),
    .wp_i(wp), .tick_i(tick), .busy_o(busy), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data));

  always @(negedge clk) if (mem_we) begin
    if (log_n < 64) begin
      log_a[log_n] = int'(mem_addr);
      log_d[log_n] = int'(mem_data);
    end
    log_n++;
  end

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic t_page(int p);
    page_ld = 1'b1; page = PAGE_W'(p);
    @(negedge clk); page_ld = 1'b0;
  endtask

  task automatic t_byte(int o, int d, bit w);
    wr_stb = 1'b1; woff = OFF_W'(o); wdat = DW'(d); wp = w;
    @(negedge clk); wr_stb = 1'b0; wp = 1'b0;
  endtask

  task automatic t_stop(bit w);
    stop = 1'b1; wp = w;
    @(negedge clk); stop = 1'b0; wp = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic add_exp(int a, int d);
    exp_a[exp_n] = a; exp_d[exp_n] = d; exp_n++;
  endtask

  task automatic cmp_log(string req);
    chk(log_n == exp_n, req, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(log_a[i] == exp_a[i], req, log_a[i], exp_a[i]);
      chk(log_d[i] == exp_d[i], req, log_d[i], exp_d[i]);
    end
  endtask

  task automatic expect_no_cycle(string req);
    for (int k = 0; k < 3; k++) begin
      chk(busy == 1'b0, req, int'(busy), 0);
      @(negedge clk);
    end
    chk(log_n == 0, req, log_n, 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, lo, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, then an empty STOP
    chk(busy == 1'b0, "R1", int'(busy), 0);
    chk(mem_we == 1'b0, "R1", int'(mem_we), 0);
    log_n = 0;
    t_stop(1'b0);
    expect_no_cycle("R1");

    // R2 R3 R4 R5 R8: sweep every non-empty mask, strobed high offset first
    for (int m = 1; m < (1 << PB); m++) begin
      log_n = 0; exp_n = 0;
      t_page(m % (1 << PAGE_W));
      lo = 0;
      while (((m >> lo) & 1) == 0) lo++;
      if (m % 2 == 1) t_byte(lo, 8'hEE, 1'b0); // later byte must replace it (R5)
      for (int o = PB - 1; o >= 0; o--)
        if (((m >> o) & 1) != 0) t_byte(o, (m * 7 + o * 13 + 1) % 256, 1'b0);
      for (int o = 0; o < PB; o++)
        if (((m >> o) & 1) != 0)
          add_exp((m % (1 << PAGE_W)) * PB + o, (m * 7 + o * 13 + 1) % 256);
      t_stop(1'b0);
      chk(busy == 1'b1, "R3", int'(busy), 1);
      wait_idle(n);
      chk(n == EW + 1, "R8", n, EW + 1);
      cmp_log((m % 2 == 1) ? "R5" : "R4");
    end

    // R10: empty STOP after a completed cycle
    log_n = 0;
    t_stop(1'b0);
    expect_no_cycle("R10");

    // R6: protected strobes on odd offsets are dropped
    log_n = 0; exp_n = 0;
    t_page(6);
    for (int o = 0; o < PB; o++) t_byte(o, 40 + o, (o % 2) == 1);
    for (int o = 0; o < PB; o += 2) add_exp(6 * PB + o, 40 + o);
    t_stop(1'b0);
    wait_idle(n);
    cmp_log("R6");

    // R6: protected STOP starts nothing and drops the buffer
    log_n = 0;
    t_page(5);
    t_byte(1, 8'h21, 1'b0);
    t_byte(2, 8'h22, 1'b0);
    t_stop(1'b1);
    expect_no_cycle("R6");
    t_stop(1'b0);
    expect_no_cycle("R6");

    // R9: inputs during busy are ignored
    log_n = 0; exp_n = 0;
    t_page(3);
    t_byte(2, 8'hA5, 1'b0);
    add_exp(3 * PB + 2, 8'hA5);
    t_stop(1'b0);
    t_page(9);
    t_byte(5, 8'h3C, 1'b0);
    t_stop(1'b0);
    wait_idle(n);
    chk(n == EW + 1 - 3, "R9", n, EW + 1 - 3);
    cmp_log("R9");
    log_n = 0;
    t_stop(1'b0);
    expect_no_cycle("R9");
    log_n = 0; exp_n = 0;
    t_byte(0, 8'h11, 1'b0);
    add_exp(3 * PB + 0, 8'h11);
    t_stop(1'b0);
    wait_idle(n);
    cmp_log("R9");

    // R11: tick high on one clock in three
    log_n = 0; exp_n = 0;
    t_page(2);
    t_byte(7, 8'h77, 1'b0);
    add_exp(2 * PB + 7, 8'h77);
    t_stop(1'b0);
    d = 0;
    while (busy && d < 5000) begin
      tick = ((d % 3) == 0);
      d++;
      @(negedge clk);
    end
    tick = 1'b1;
    chk(d == 3 * EW - 1, "R11", d, 3 * EW - 1);
    cmp_log("R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule